// File: doc/BRIEF.md
# Parallel Decision-Path Chain Matcher

This block classifies samples of a labelled byte stream against many decision-tree paths at once. Each decision-tree path from root to leaf is held as a linear chain of stages. Stage k of a chain holds an inclusive label range for the k-th feature. All chains sit in a shared feature order, and a feature that a path does not test gets a range that spans every label of that feature. Every chain watches the same byte stream, one byte per accepted cycle.

A sample is a run of feature labels ended by the delimiter 0xFF. A delimiter re-arms every chain, so the next byte is tested against stage 0. Each matching byte advances the chain by one stage. Any mismatch leaves the chain idle until the next delimiter. A chain that has matched all of its features reports when the next byte is the delimiter.

Reports from one delimiter are grouped and queued. They are then issued one per accepted cycle, lowest chain first. Each report carries the chain number, the chain's class, its tree id and the stream offset of the delimiter. When the queue is full, an arriving group is dropped and the drop is flagged.

Top module: `chain_matcher`

## Requirements
- R1: After reset, `rpt_valid` and `rpt_ovf` are 0. Bytes received before the first delimiter can never lead to a report, because the first delimiter is what arms the chains.
- R2: Stage k of a chain accepts the k-th byte after a delimiter when `lo <= byte <= hi`, with both bounds included.
- R3: A chain reports only on a delimiter byte that directly follows a match of its last feature stage. The report offset is the zero-based count of accepted bytes before that delimiter. The report becomes visible in the cycle after the delimiter is accepted.
- R4: A byte outside a stage's range kills the chain for the rest of the sample. A non-delimiter byte that arrives after the last feature has matched also kills it.
- R5: A delimiter ends any partial sample without a report, and it re-arms every chain for a fresh sample.
- R6: A byte presented while `in_valid` is 0 has no effect: chain progress and the offset count are unchanged.
- R7: Reports raised by one delimiter share its offset. They are issued one per cycle with `rpt_ready` high, in ascending chain number.
- R8: `rpt_class` and `rpt_tree` are the values written to the reporting chain through `cfg_sel` = 1. The class comes from `cfg_lo[3:0]` and the tree id from `cfg_hi[3:0]`.
- R9: While `rpt_ready` is 0, a pending report holds `rpt_valid` high and keeps its fields stable.
- R10: The queue holds DEPTH (4) delimiter groups. A group that arrives while the queue is full is discarded, and `rpt_ovf` is high for one cycle, starting the cycle after that delimiter. Groups already queued are not changed.
- R11: After reset every stage range is empty (lo = 0xFF, hi = 0x00), so a chain that has not been configured never reports.
- R12: Writing `cfg_sel` = 2 sets the number of feature stages for all chains to `cfg_lo`, limited to the range 1 to NSTAGE. A sample must then have exactly that many labels before its delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte: a label or the delimiter 0xFF |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 = stage range, 1 = class/tree, 2 = feature count |
| cfg_chain | input | 4 | Chain number |
| cfg_stage | input | 3 | Stage number (range writes) |
| cfg_lo | input | 8 | Low bound, class in [3:0], or feature count |
| cfg_hi | input | 8 | High bound, or tree id in [3:0] |
| rpt_ready | input | 1 | Consumer accepts the current report |
| rpt_valid | output | 1 | A report is pending |
| rpt_chain | output | 4 | Reporting chain number |
| rpt_class | output | 4 | Class of the reporting chain |
| rpt_tree | output | 4 | Tree id of the reporting chain |
| rpt_offset | output | 16 | Stream offset of the delimiter that caused the report |
| rpt_ovf | output | 1 | One-cycle pulse: a report group was dropped |

## Verification
A chain left in the wrong stage shows up at the next delimiter. It appears either as a missing report from the one chain per tree that should have matched, or as an extra report from a chain that should have been killed. Both are visible one cycle after the delimiter. A wrong range bound only shows up when a label sits exactly on that bound, so the samples use labels at both edges of their ranges. A fault in the queue pointers or masks shows up as wrong order, wrong offsets or missing reports while a group drains. That is checked by draining several multi-report groups, including groups held under back-pressure and one group dropped on overflow.

// File: rtl/chain_matcher.sv
module chain_matcher #(
  parameter int NCHAIN = 16,
  parameter int NSTAGE = 8,
  parameter int LW     = 8,
  parameter int CW     = 4,
  parameter int TW     = 4,
  parameter int OW     = 16,
  parameter int DEPTH  = 4,
  parameter logic [LW-1:0] DELIM = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [LW-1:0]             in_byte,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [$clog2(NCHAIN)-1:0] cfg_chain,
  input  logic [$clog2(NSTAGE)-1:0] cfg_stage,
  input  logic [LW-1:0]             cfg_lo,
  input  logic [LW-1:0]             cfg_hi,
  input  logic                      rpt_ready,
  output logic                      rpt_valid,
  output logic [$clog2(NCHAIN)-1:0] rpt_chain,
  output logic [CW-1:0]             rpt_class,
  output logic [TW-1:0]             rpt_tree,
  output logic [OW-1:0]             rpt_offset,
  output logic                      rpt_ovf
);
  localparam int IW = $clog2(NCHAIN);
  localparam int NW = $clog2(NSTAGE + 1);
  localparam int PW = $clog2(DEPTH);
  localparam int KW = $clog2(DEPTH + 1);

  logic [LW-1:0] lo_q   [NCHAIN][NSTAGE];
  logic [LW-1:0] hi_q   [NCHAIN][NSTAGE];
  logic [CW-1:0] cls_q  [NCHAIN];
  logic [TW-1:0] tree_q [NCHAIN];
  logic [NW-1:0] nfeat_q;
  logic [NSTAGE:0] act_q [NCHAIN];
  logic [NCHAIN-1:0] hit;
  logic [OW-1:0] off_q;

  wire is_delim = in_valid && (in_byte == DELIM);

  // configuration store
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHAIN; c++) begin
        cls_q[c]  <= '0;
        tree_q[c] <= '0;
        for (int k = 0; k < NSTAGE; k++) begin
          lo_q[c][k] <= '1;
          hi_q[c][k] <= '0;
        end
      end
      nfeat_q <= NW'(NSTAGE);
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin
          lo_q[cfg_chain][cfg_stage] <= cfg_lo;
          hi_q[cfg_chain][cfg_stage] <= cfg_hi;
        end
        2'd1: begin
          cls_q[cfg_chain]  <= cfg_lo[CW-1:0];
          tree_q[cfg_chain] <= cfg_hi[TW-1:0];
        end
        2'd2: begin
          if (cfg_lo == '0)                nfeat_q <= NW'(1);
          else if (cfg_lo > LW'(NSTAGE))   nfeat_q <= NW'(NSTAGE);
          else                             nfeat_q <= cfg_lo[NW-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        off_q <= '0;
    else if (in_valid) off_q <= off_q + 1'b1;
  end

  // chain array
  for (genvar c = 0; c < NCHAIN; c++) begin : g_ch
    logic [NSTAGE-1:0] ok;
    for (genvar k = 0; k < NSTAGE; k++) begin : g_st
      assign ok[k] = act_q[c][k] && (NW'(k) < nfeat_q) &&
                     (in_byte >= lo_q[c][k]) && (in_byte <= hi_q[c][k]);
    end
    assign hit[c] = is_delim && act_q[c][nfeat_q];

    always_ff @(posedge clk) begin
      if (!rst_n)        act_q[c] <= '0;
      else if (is_delim) act_q[c] <= (NSTAGE+1)'(1);
      else if (in_valid) act_q[c] <= {ok, 1'b0};
    end

    AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_q[c])); // R4
  end

  // report queue: one entry per delimiter group, drained lowest chain first
  logic [NCHAIN-1:0] mask_q [DEPTH];
  logic [OW-1:0]     offm_q [DEPTH];
  logic [PW-1:0]     rd_q, wr_q;
  logic [KW-1:0]     cnt_q;
  logic              ovf_q;
  logic [NCHAIN-1:0] head;
  logic [IW-1:0]     sel;
  logic              last, full, push_req, do_push, pop_one, pop_entry;

  assign head = mask_q[rd_q];
  always_comb begin
    sel = '0;
    for (int i = NCHAIN - 1; i >= 0; i--)
      if (head[i]) sel = IW'(i);
  end

  assign last      = (head & (head - 1'b1)) == '0;
  assign full      = cnt_q == KW'(DEPTH);
  assign push_req  = |hit;
  assign do_push   = push_req && !full;
  assign pop_one   = rpt_valid && rpt_ready;
  assign pop_entry = pop_one && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
        mask_q[e] <= '0;
        offm_q[e] <= '0;
      end
    end else begin
      ovf_q <= push_req && full;
      if (do_push) begin
        mask_q[wr_q] <= hit;
        offm_q[wr_q] <= off_q;
        wr_q         <= wr_q + 1'b1;
      end
      if (pop_one && !last) mask_q[rd_q][sel] <= 1'b0;
      if (pop_entry)        rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + KW'(do_push) - KW'(pop_entry);
    end
  end

  assign rpt_valid  = cnt_q != '0;
  assign rpt_chain  = sel;
  assign rpt_class  = cls_q[sel];
  assign rpt_tree   = tree_q[sel];
  assign rpt_offset = offm_q[rd_q];
  assign rpt_ovf    = ovf_q;

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_one && !last) |=> (rpt_chain > $past(rpt_chain))); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_chain) && $stable(rpt_offset))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= KW'(DEPTH)); // R10
  AST_OVF_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_ovf |-> rpt_valid); // R10
  AST_RPT_FROM_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid) |-> $past(in_valid && in_byte == DELIM)); // R3
endmodule

// File: tb/sim_chain_matcher.sv
module sim_chain_matcher;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [7:0] in_byte = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [3:0] cfg_chain = 0;
  logic [2:0] cfg_stage = 0;
  logic [7:0] cfg_lo = 0, cfg_hi = 0;
  logic rpt_ready = 0;
  logic rpt_valid, rpt_ovf;
  logic [3:0] rpt_chain, rpt_class, rpt_tree;
  logic [15:0] rpt_offset;

  int checks = 0, errors = 0, pos = 0, last_off = 0;
  int goff [5];
  bit done = 0;

  always #10 clk = ~clk;

  chain_matcher u0 (
    .clk, .rst_n, .in_valid, .in_byte, .cfg_we, .cfg_sel, .cfg_chain, .cfg_stage,
    .cfg_lo, .cfg_hi, .rpt_ready, .rpt_valid, .rpt_chain, .rpt_class, .rpt_tree,
    .rpt_offset, .rpt_ovf
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int ch, input int st, input int lo, input int hi);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_chain = 4'(ch); cfg_stage = 3'(st);
    cfg_lo = 8'(lo); cfg_hi = 8'(hi);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic chain3(input int ch, input int a0, input int a1, input int b0,
                        input int b1, input int c0, input int c1, input int cls, input int tr);
    cfg(0, ch, 0, a0, a1);
    cfg(0, ch, 1, b0, b1);
    cfg(0, ch, 2, c0, c1);
    cfg(1, ch, 0, cls, tr);
  endtask

  task automatic send(input int b);
    in_valid = 1; in_byte = 8'(b);
    @(negedge clk);
    in_valid = 0;
    pos++;
  endtask

  task automatic sample(input int a, input int b, input int c);
    send(a); send(b); send(c); send(8'hFF);
    last_off = pos - 1;
  endtask

  task automatic expect_rpt(input string req, input int ch, input int cls, input int tr, input int off);
    chk(req, int'(rpt_valid), 1);
    chk(req, int'(rpt_chain), ch);
    chk(req, int'(rpt_class), cls);
    chk(req, int'(rpt_tree), tr);
    chk(req, int'(rpt_offset), off);
    rpt_ready = 1;
    @(negedge clk);
    rpt_ready = 0;
  endtask

  task automatic expect_none(input string req);
    chk(req, int'(rpt_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", int'(rpt_valid), 0);
    chk("R1 ovf after reset", int'(rpt_ovf), 0);
  endtask

  task automatic t_unarmed;
    sample(0, 4, 7); // first delimiter only arms
    expect_none("R1 no report before arming");
  endtask

  task automatic t_basic;
    sample(1, 4, 8);
    expect_rpt("R7 R8 R3 first", 0, 2, 1, last_off);
    expect_rpt("R7 R8 R3 second", 5, 1, 3, last_off);
    expect_none("R11 unconfigured silent");
  endtask

  task automatic t_bounds;
    sample(3, 6, 8); // upper bounds
    expect_rpt("R2 hi bound tree1", 3, 9, 1, last_off);
    expect_rpt("R2 hi bound tree3", 9, 4, 3, last_off);
    expect_none("R2 hi group end");
    sample(2, 4, 7); // lower bounds
    expect_rpt("R2 lo bound tree1", 1, 5, 1, last_off);
    expect_rpt("R2 lo bound tree3", 5, 1, 3, last_off);
    expect_none("R2 lo group end");
  endtask

  task automatic t_kill;
    sample(1, 4, 8'h0B);
    expect_none("R4 out of range");
    send(1); send(4); send(8); send(8); send(8'hFF);
    expect_none("R4 extra byte");
  endtask

  task automatic t_abort;
    send(1); send(4); send(8'hFF);
    expect_none("R5 partial sample");
    sample(1, 4, 8);
    expect_rpt("R5 rearmed", 0, 2, 1, last_off);
    expect_rpt("R5 rearmed b", 5, 1, 3, last_off);
  endtask

  task automatic t_gaps;
    send(1);
    in_byte = 8'hFF; @(negedge clk);  // invalid delimiter
    in_byte = 8'h20; @(negedge clk);
    send(4);
    in_byte = 8'hFF; @(negedge clk);
    send(8); send(8'hFF);
    last_off = pos - 1;
    expect_rpt("R6 gaps ignored", 0, 2, 1, last_off);
    expect_rpt("R6 gaps ignored b", 5, 1, 3, last_off);
  endtask

  task automatic t_stall;
    sample(2, 5, 7);
    for (int i = 0; i < 3; i++) begin
      chk("R9 held valid", int'(rpt_valid), 1);
      chk("R9 held chain", int'(rpt_chain), 2);
      chk("R9 held offset", int'(rpt_offset), last_off);
      @(negedge clk);
    end
    expect_rpt("R9 after stall", 2, 7, 1, last_off);
    expect_rpt("R9 after stall b", 5, 1, 3, last_off);
    expect_none("R9 drained");
  endtask

  task automatic t_overflow;
    for (int g = 0; g < 5; g++) begin
      sample(1, 4, 8);
      goff[g] = last_off;
      if (g < 4) chk("R10 no ovf before full", int'(rpt_ovf), 0);
    end
    chk("R10 ovf pulse", int'(rpt_ovf), 1);
    @(negedge clk);
    chk("R10 ovf one cycle", int'(rpt_ovf), 0);
    for (int g = 0; g < 4; g++) begin
      expect_rpt("R10 kept group", 0, 2, 1, goff[g]);
      expect_rpt("R10 kept group b", 5, 1, 3, goff[g]);
    end
    expect_none("R10 dropped group absent");
  endtask

  task automatic t_nfeat;
    cfg(2, 0, 0, 2, 0);
    send(1); send(4); send(8'hFF);
    last_off = pos - 1;
    expect_rpt("R12 two features", 0, 2, 1, last_off);
    expect_rpt("R12 two features b", 5, 1, 3, last_off);
    sample(1, 4, 8);
    expect_none("R12 third label kills");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    cfg(2, 0, 0, 3, 0);
    chain3(0, 0, 1, 4, 6, 7, 8, 2, 1);
    chain3(1, 2, 3, 4, 4, 7, 8, 5, 1);
    chain3(2, 2, 3, 5, 6, 7, 7, 7, 1);
    chain3(3, 2, 3, 5, 6, 8, 8, 9, 1);
    chain3(5, 0, 3, 4, 5, 7, 8, 1, 3);
    chain3(9, 0, 3, 6, 6, 7, 8, 4, 3);
    t_unarmed;
    t_basic;
    t_bounds;
    t_kill;
    t_abort;
    t_gaps;
    t_stall;
    t_overflow;
    t_nfeat;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule